// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Per-Field Wildcards

This block watches a real-time clock's hours, minutes and seconds and raises an alarm event when they reach a programmed alarm time. The comparison happens only on the cycle in which the timekeeping logic reports that an update has finished, never continuously. A match sets a sticky alarm flag. When the alarm is enabled, the flag also drives an active-low interrupt request that comes straight from a register, so the request cannot glitch. The comparison needs no bus activity, so the alarm can wake a system that is running on its backup supply.

Any of the three alarm bytes can be taken out of the comparison by writing it with both of its top bits set. This wildcard lets one block give alarms once a day, once an hour, once a minute or once a second. Software reads a status byte to collect the flag, and the read also clears it. If a new match arrives in the same cycle as that read, the new match wins, so an event is never lost.

Top module: `rtc_alarm_cmp`

## Requirements
- R1: After reset, all three alarm bytes and the enable bit are 0, the status byte reads 0x00 and `irq_n` is 1.
- R2: The alarm flag (status bit 5) changes only on a clock edge where `upd_done` or `stat_rd` is 1. Matching time bytes with `upd_done` low never set it.
- R3: On an edge with `upd_done` high, when every compared field of {`hour_now`,`min_now`,`sec_now`} equals its alarm byte, status bit 5 is 1 from the next cycle on.
- R4: An alarm byte with bits [7:6] = 2'b11 is a wildcard and is left out of the comparison. The codes 2'b10 and 2'b01 in those bits are compared normally.
- R5: Across a full sweep of three hours of updates with alarm 01:02:03, the flag sets once with no wildcard, three times with only the hour wildcarded, 180 times with hour and minute wildcarded, and 10800 times with all three wildcarded.
- R6: The flag sets whether or not the alarm is enabled. `irq_n` is 0 exactly when the flag is set and the enable bit is 1, and it changes on the same edge as the state that causes it.
- R7: Status bit 5 reads the flag, bit 7 reads the flag ANDed with the enable bit, and all other bits read 0. An edge with `stat_rd` high clears the flag, and `irq_n` returns to 1 on that edge.
- R8: When `upd_done` with a match and `stat_rd` fall on the same edge, the flag stays 1.
- R9: A write with `wr_sel` = 0, 1 or 2 loads the second, minute or hour alarm byte. `wr_sel` = 3 loads the enable bit from `wr_data[5]`. Clearing the enable bit leaves the flag set and raises `irq_n` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 second, 1 minute, 2 hour alarm byte, 3 control |
| wr_data | input | 8 | Write data |
| sec_now | input | 8 | Current seconds byte |
| min_now | input | 8 | Current minutes byte |
| hour_now | input | 8 | Current hours byte |
| upd_done | input | 1 | One-cycle strobe: the time update has completed |
| stat_rd | input | 1 | Status read strobe; clears the alarm flag |
| stat_q | output | 8 | Status byte: bit 7 pending interrupt, bit 5 alarm flag |
| irq_n | output | 1 | Registered interrupt request, active low |

## Verification
The main comparison is tried with five kinds of input: a time that differs in exactly one field, an exact match with the strobe held low, an exact match with the strobe high, matches under each wildcard combination, and the near-wildcard codes 2'b10 and 2'b01. Together these show that each field takes part in the match, that the strobe gates the comparison, and that only 2'b11 masks a field. A three-hour time sweep under each wildcard setting counts events, which tells the day, hour, minute and second rates apart. Directed cases pair a read with a simultaneous match and toggle the enable bit, which separates the flag from the interrupt. A behavioural model in the bench follows every cycle.

// File: rtl/rtc_alarm_pkg.sv
// Package: shared constants, register selects and the wildcard test for the
// alarm comparator. Assumes byte-wide time fields.
package rtc_alarm_pkg;

    localparam int ALM_BYTE_W = 8;
    localparam int ALM_FIELDS = 3;

    // Control and status bit positions
    localparam int CTRL_EN_BIT = 5;
    localparam int STAT_AF_BIT = 5;
    localparam int STAT_IRQ_BIT = 7;

    // Register select codes of the write port
    typedef enum logic [1:0] {
        SEL_SEC  = 2'd0,
        SEL_MIN  = 2'd1,
        SEL_HOUR = 2'd2,
        SEL_CTRL = 2'd3
    } alm_sel_e;

    // A field whose two top bits are both set is excluded from the compare
    function automatic logic is_wildcard(input logic [1:0] top_bits);
        return top_bits == 2'b11;
    endfunction

endpackage

// File: rtl/rtc_alarm_regs.sv
// Module: holds the alarm bytes and the alarm enable bit.
// Assumes select codes 0..FIELDS-1 address alarm bytes, code FIELDS the
// control byte. Also gives the enable value that takes effect at this edge.
module rtc_alarm_regs #(
    parameter int BYTE_W = rtc_alarm_pkg::ALM_BYTE_W,
    parameter int FIELDS = rtc_alarm_pkg::ALM_FIELDS,
    parameter int EN_BIT = rtc_alarm_pkg::CTRL_EN_BIT,
    localparam int SEL_W = $clog2(FIELDS + 1),
    localparam int FLAT_W = FIELDS * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [FLAT_W-1:0] alarm_flat,
    output logic              en_q,
    output logic              en_next
);

    localparam logic [SEL_W-1:0] CTRL_SEL = SEL_W'(FIELDS);

    genvar gi;
    generate
        for (gi = 0; gi < FIELDS; gi++) begin : g_byte
            localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(gi);
            logic [BYTE_W-1:0] byte_q;

            // Load this alarm byte when the write port addresses it
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    byte_q <= '0;
                end else if (wr_en && (wr_sel == MY_SEL)) begin
                    byte_q <= wr_data;
                end
            end

            assign alarm_flat[gi*BYTE_W +: BYTE_W] = byte_q;
        end
    endgenerate

    // Enable value after this edge's write, if any
    always_comb begin
        en_next = en_q;
        if (wr_en && (wr_sel == CTRL_SEL)) begin
            en_next = wr_data[EN_BIT];
        end
    end

    // Hold the alarm enable bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_next;
        end
    end

endmodule

// File: rtl/rtc_alarm_match.sv
// Module: compares each time field with its alarm byte. A field coded as a
// wildcard always counts as matching. Purely combinational; the caller
// qualifies the result with the update strobe.
module rtc_alarm_match #(
    parameter int BYTE_W = rtc_alarm_pkg::ALM_BYTE_W,
    parameter int FIELDS = rtc_alarm_pkg::ALM_FIELDS,
    localparam int FLAT_W = FIELDS * BYTE_W
) (
    input  logic [FLAT_W-1:0] alarm_flat,
    input  logic [FLAT_W-1:0] now_flat,
    output logic              hit
);

    logic [FIELDS-1:0] field_ok;

    genvar gi;
    generate
        for (gi = 0; gi < FIELDS; gi++) begin : g_cmp
            logic [BYTE_W-1:0] alm_b;
            logic [BYTE_W-1:0] now_b;
            logic              wild;

            assign alm_b = alarm_flat[gi*BYTE_W +: BYTE_W];
            assign now_b = now_flat[gi*BYTE_W +: BYTE_W];

            // Decide wildcard status and per-field equality
            always_comb begin
                wild         = rtc_alarm_pkg::is_wildcard(alm_b[BYTE_W-1 -: 2]);
                field_ok[gi] = wild || (alm_b == now_b);
            end
        end
    endgenerate

    // All fields must agree
    assign hit = &field_ok;

endmodule

// File: rtl/rtc_alarm_flag.sv
// Module: sticky alarm flag with clear-on-read, plus the registered
// interrupt request. A new set takes priority over a clear on the same edge.
// Assumes en_next is the enable value that holds after this edge.
module rtc_alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_done,
    input  logic hit,
    input  logic rd_clr,
    input  logic en_next,
    output logic af_q,
    output logic irq_q
);

    logic set_evt;
    logic af_next;

    // Next flag value: set wins over clear
    always_comb begin
        set_evt = upd_done && hit;
        if (set_evt) begin
            af_next = 1'b1;
        end else if (rd_clr) begin
            af_next = 1'b0;
        end else begin
            af_next = af_q;
        end
    end

    // Register the flag and a glitch-free interrupt request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            af_q  <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            af_q  <= af_next;
            irq_q <= af_next && en_next;
        end
    end

endmodule

// File: rtl/rtc_alarm_cmp.sv
// Module: top of the alarm comparator. Ties the register bank, the
// field comparator and the flag logic together and forms the status byte.
// Assumes upd_done is a one-cycle strobe issued after the time bytes settle.
module rtc_alarm_cmp #(
    parameter int BYTE_W = rtc_alarm_pkg::ALM_BYTE_W,
    localparam int FIELDS = rtc_alarm_pkg::ALM_FIELDS,
    localparam int SEL_W = $clog2(FIELDS + 1),
    localparam int FLAT_W = FIELDS * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] sec_now,
    input  logic [BYTE_W-1:0] min_now,
    input  logic [BYTE_W-1:0] hour_now,
    input  logic              upd_done,
    input  logic              stat_rd,
    output logic [BYTE_W-1:0] stat_q,
    output logic              irq_n
);

    logic [FLAT_W-1:0] alarm_flat;
    logic [FLAT_W-1:0] now_flat;
    logic              en_q;
    logic              en_next;
    logic              hit;
    logic              af_q;
    logic              irq_q;

    // Field order: seconds lowest, hours highest
    assign now_flat = {hour_now, min_now, sec_now};

    rtc_alarm_regs #(
        .BYTE_W (BYTE_W),
        .FIELDS (FIELDS),
        .EN_BIT (rtc_alarm_pkg::CTRL_EN_BIT)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .alarm_flat (alarm_flat),
        .en_q       (en_q),
        .en_next    (en_next)
    );

    rtc_alarm_match #(
        .BYTE_W (BYTE_W),
        .FIELDS (FIELDS)
    ) u_match (
        .alarm_flat (alarm_flat),
        .now_flat   (now_flat),
        .hit        (hit)
    );

    rtc_alarm_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_done (upd_done),
        .hit      (hit),
        .rd_clr   (stat_rd),
        .en_next  (en_next),
        .af_q     (af_q),
        .irq_q    (irq_q)
    );

    // Assemble the status byte from the flag and enable state
    always_comb begin
        stat_q = '0;
        stat_q[rtc_alarm_pkg::STAT_AF_BIT]  = af_q;
        stat_q[rtc_alarm_pkg::STAT_IRQ_BIT] = af_q && en_q;
    end

    assign irq_n = !irq_q;

endmodule

// File: rtl/rtc_alarm_chk.sv
// Module: assertion checker for rtc_alarm_cmp, attached through bind.
// Watches the ports plus the comparator's hit output.
module rtc_alarm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       upd_done,
    input logic       stat_rd,
    input logic       hit,
    input logic [7:0] stat_q,
    input logic       irq_n
);

    // R2
    flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_done && !stat_rd) |=> $stable(stat_q[5]));

    // R3
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_done && hit) |=> stat_q[5]);

    // R6
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> stat_q[5]);

    // R7
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !(upd_done && hit)) |=> (!stat_q[5] && irq_n));

    // R8
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && upd_done && hit) |=> stat_q[5]);

    // R7
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[4:0] == 5'd0) && !stat_q[6]);

endmodule

bind rtc_alarm_cmp rtc_alarm_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_done (upd_done),
    .stat_rd  (stat_rd),
    .hit      (hit),
    .stat_q   (stat_q),
    .irq_n    (irq_n)
);

// File: tb/rtc_alarm_cmp_bench.sv
module rtc_alarm_cmp_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] sec_now = 8'd0;
    logic [7:0] min_now = 8'd0;
    logic [7:0] hour_now = 8'd0;
    logic       upd_done = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] stat_q;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference model state
    logic [7:0] m_alarm [3];
    logic       m_en = 1'b0;
    logic       m_af = 1'b0;
    logic       m_irq = 1'b0;

    always #5 clk = ~clk;

    rtc_alarm_cmp u_rtc_alarm_cmp (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .sec_now(sec_now), .min_now(min_now),
        .hour_now(hour_now), .upd_done(upd_done), .stat_rd(stat_rd),
        .stat_q(stat_q), .irq_n(irq_n)
    );

    function automatic bit field_match(input logic [7:0] a, input logic [7:0] n);
        return (a[7:6] == 2'b11) || (a == n);
    endfunction

    // Behavioural reference: updated on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) m_alarm[i] = 8'd0;
            m_en = 0; m_af = 0; m_irq = 0;
        end else begin
            bit hit;
            hit = field_match(m_alarm[0], sec_now) && field_match(m_alarm[1], min_now)
                  && field_match(m_alarm[2], hour_now);
            if (upd_done && hit) m_af = 1;
            else if (stat_rd) m_af = 0;
            if (wr_en) begin
                if (wr_sel == 2'd3) m_en = wr_data[5];
                else m_alarm[wr_sel] = wr_data;
            end
            m_irq = m_af && m_en;
        end
    end

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [7:0] exp_stat;
            exp_stat = {m_af && m_en, 1'b0, m_af, 5'd0};
            checks++;
            if (stat_q !== exp_stat) begin
                errors++;
                $display("FAIL R7 model status: got %02h expected %02h", stat_q, exp_stat);
            end
            checks++;
            if (irq_n !== !m_irq) begin
                errors++;
                $display("FAIL R6 model irq_n: got %0b expected %0b", irq_n, !m_irq);
            end
        end
    end

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // One cycle: inputs set after a falling edge, held across the rising edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; upd_done = 0; stat_rd = 0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
        step();
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        hour_now = h; min_now = m; sec_now = s;
    endtask

    task automatic update(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        set_time(h, m, s); upd_done = 1;
        step();
    endtask

    task automatic clear_flag();
        stat_rd = 1;
        step();
    endtask

    // Sweep three hours of seconds, counting flag sets
    task automatic sweep(input logic [7:0] ah, input logic [7:0] am,
                         input logic [7:0] as_, input int exp_cnt, input string tag);
        int cnt = 0;
        wr(2'd2, ah); wr(2'd1, am); wr(2'd0, as_);
        for (int h = 0; h < 3; h++)
            for (int m = 0; m < 60; m++)
                for (int s = 0; s < 60; s++) begin
                    update(8'(h), 8'(m), 8'(s));
                    if (stat_q[5]) begin
                        cnt++;
                        clear_flag();
                    end
                end
        checks++;
        if (cnt != exp_cnt) begin
            errors++;
            $display("FAIL %s: got %0d events expected %0d", tag, cnt, exp_cnt);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 status after reset", stat_q, 8'h00);
        check("R1 irq_n after reset", {7'd0, irq_n}, 8'h01);
        update(8'h00, 8'h00, 8'h00);
        check("R1 zero alarm bytes match 00:00:00", stat_q, 8'h20);
        clear_flag();

        // R9 program 12:34:56 and enable
        wr(2'd2, 8'h12); wr(2'd1, 8'h34); wr(2'd0, 8'h56);
        wr(2'd3, 8'h20);
        check("R9 enable with no flag", stat_q, 8'h00);

        // R2 match without strobe
        set_time(8'h12, 8'h34, 8'h56);
        step(); step();
        check("R2 no strobe no flag", stat_q, 8'h00);

        // R3 single field mismatches
        update(8'h12, 8'h34, 8'h57);
        check("R3 seconds differ", stat_q, 8'h00);
        update(8'h12, 8'h35, 8'h56);
        check("R3 minutes differ", stat_q, 8'h00);
        update(8'h13, 8'h34, 8'h56);
        check("R3 hours differ", stat_q, 8'h00);
        update(8'h12, 8'h34, 8'h56);
        check("R3 full match sets flag", stat_q, 8'hA0);
        check("R6 irq asserted", {7'd0, irq_n}, 8'h00);

        // R2 flag holds without strobe or read
        set_time(8'h00, 8'h00, 8'h00);
        step();
        check("R2 flag sticky", stat_q, 8'hA0);

        // R7 read clears flag and irq
        clear_flag();
        check("R7 read clears flag", stat_q, 8'h00);
        check("R7 irq released", {7'd0, irq_n}, 8'h01);

        // R8 simultaneous set and read
        set_time(8'h12, 8'h34, 8'h56); upd_done = 1; stat_rd = 1;
        step();
        check("R8 set beats clear", stat_q, 8'hA0);

        // R9 disable keeps flag, releases irq
        wr(2'd3, 8'h00);
        check("R9 flag kept after disable", stat_q, 8'h20);
        check("R9 irq released after disable", {7'd0, irq_n}, 8'h01);
        clear_flag();

        // R6 flag sets while disabled, no irq
        update(8'h12, 8'h34, 8'h56);
        check("R6 flag without enable", stat_q, 8'h20);
        check("R6 no irq when disabled", {7'd0, irq_n}, 8'h01);
        wr(2'd3, 8'h20);
        check("R6 irq once enabled", {7'd0, irq_n}, 8'h00);
        clear_flag();

        // R4 wildcard versus near codes in the hour byte
        wr(2'd2, 8'hC0);
        update(8'h07, 8'h34, 8'h56);
        check("R4 hour wildcard 11", stat_q, 8'hA0);
        clear_flag();
        wr(2'd2, 8'h80);
        update(8'h07, 8'h34, 8'h56);
        check("R4 code 10 compared", stat_q, 8'h00);
        update(8'h80, 8'h34, 8'h56);
        check("R4 code 10 exact", stat_q, 8'hA0);
        clear_flag();
        wr(2'd2, 8'h40);
        update(8'h07, 8'h34, 8'h56);
        check("R4 code 01 compared", stat_q, 8'h00);

        // R5 alarm rates over a three-hour sweep
        wr(2'd3, 8'h00);
        sweep(8'h01, 8'h02, 8'h03, 1, "R5 daily rate");
        sweep(8'hC0, 8'h02, 8'h03, 3, "R5 hourly rate");
        sweep(8'hC0, 8'hC0, 8'h03, 180, "R5 minute rate");
        sweep(8'hC0, 8'hC0, 8'hFF, 10800, "R5 second rate");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule